// File: doc/BRIEF.md
# TDM Frame Sync Pulse Generator

This block drives the per-channel frame sync strobes of a time-division serial highway. It runs on the bit clock. Each frame has up to 64 time slots of eight bit clocks each. For each direction, a frame-start sync input restarts a slot counter. Eight outputs each rise for exactly one slot, the one named in their entry of an assignment table. Four outputs serve the transmit side and four serve the receive side. A shared active-low flag marks every slot in which a transmit strobe is high.

The table is supplied by a separate control block as plain, level-held pins. The block reads the table only at slot boundaries, so a table write never truncates a strobe already in progress. It has no data stream, so it has no valid/ready handshake. All pins are plain control and status signals.

There are two timing modes. In the split mode, the receive strobes follow their own frame-start sync, which may have any phase relative to the transmit one. In the shared mode, all eight strobes follow the transmit sync, and the receive sync pin is free for use as a channel-select bit elsewhere.

Top module: `fsg_top`

## Requirements
- R1: After reset, every strobe stays low and `tx_active_n` stays high until that direction's first frame-start sync has been sampled high.
- R2: A sync sampled high at a rising edge restarts its direction at slot 0, bit 0. A strobe assigned to slot 0 is high at the next sample point after that edge.
- R3: A strobe assigned to slot s rises at the edge 8*s after the sync edge and stays high for exactly 8 bit clocks.
- R4: With no new sync, slot 63 is followed by slot 0, so a strobe repeats every 512 bit clocks.
- R5: An output whose enable bit is 0 stays low for the whole frame.
- R6: Slots 0 and 63 are both valid assignments. Several outputs may hold the same slot and then pulse together.
- R7: With `mode_shared`=0, the receive strobes are timed only from `rx_sync`.
- R8: With `mode_shared`=1, all eight strobes are timed from `tx_sync`, and `rx_sync` has no effect.
- R9: `tx_active_n` is low in exactly those cycles in which any `tx_fs` bit is high.
- R10: A table or enable change takes effect only at the next slot boundary. A strobe in progress still completes its 8 cycles.
- R11: Table entry k occupies `slot_tbl[6k+5:6k]`, and its enable bit is `slot_en[k]`. Entries 0 to 3 drive `tx_fs[0..3]`, and entries 4 to 7 drive `rx_fs[0..3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_shared | input | 1 | 0 = split timing, 1 = all strobes from transmit sync |
| tx_sync | input | 1 | Transmit frame-start sync |
| rx_sync | input | 1 | Receive frame-start sync (ignored when shared) |
| slot_tbl | input | 48 | Eight 6-bit slot assignments |
| slot_en | input | 8 | Per-entry assignment enable |
| tx_fs | output | 4 | Transmit frame sync strobes |
| rx_fs | output | 4 | Receive frame sync strobes |
| tx_active_n | output | 1 | Low while any transmit strobe is high |

## Verification
Every strobe is registered, so a sync or a slot boundary seen at a rising edge shows at the outputs in the same clock period. Slot s therefore appears from edge 8*s after the sync edge. `tx_active_n` follows the transmit strobes with no extra delay. The bench drives inputs just after a falling edge and samples all outputs at the next falling edge. It counts cycles from the edge that took the sync, so that each rise and fall index can be compared with 8*s and 8*s+8. A bench model steps once per rising edge and is compared at every sample point during constrained-random runs.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned FSG_SLOT_W      = 6;
  localparam int unsigned FSG_BIT_W       = 3;
  localparam int unsigned FSG_CH_PER_DIR  = 4;

  // Which frame counter times the receive-side strobes.
  typedef enum logic {SRC_TX = 1'b0, SRC_RX = 1'b1} cnt_src_e;

  function automatic cnt_src_e rx_source(input logic shared);
    return shared ? SRC_TX : SRC_RX;
  endfunction
endpackage

// File: rtl/fsg_frame_counter.sv
module fsg_frame_counter #(
  parameter int unsigned SLOT_W = 6,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  output logic [SLOT_W-1:0] slot_nxt_o,
  output logic              boundary_o,
  output logic              locked_nxt_o
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = '1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q, bit_nxt;
  logic              locked_q;

  always_comb begin
    if (sync_i) begin
      slot_nxt_o = '0;
      bit_nxt    = '0;
    end else if (bit_q == BIT_LAST) begin
      slot_nxt_o = slot_q + 1'b1;
      bit_nxt    = '0;
    end else begin
      slot_nxt_o = slot_q;
      bit_nxt    = bit_q + 1'b1;
    end
  end

  assign boundary_o   = (bit_nxt == '0);
  assign locked_nxt_o = locked_q | sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= SLOT_LAST;
      bit_q    <= BIT_LAST;
      locked_q <= 1'b0;
    end else begin
      slot_q   <= slot_nxt_o;
      bit_q    <= bit_nxt;
      locked_q <= locked_nxt_o;
    end
  end

  // R2: a sampled sync restarts the frame at slot 0, bit 0
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (slot_q == '0 && bit_q == '0 && locked_q));

  // R4: slot 63 rolls over to slot 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && slot_q == SLOT_LAST && bit_q == BIT_LAST) |=> (slot_q == '0 && bit_q == '0));

  // R3: inside a slot the bit count advances and the slot holds
  a_r3_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && bit_q != BIT_LAST) |=> (bit_q == $past(bit_q) + 1'b1 && $stable(slot_q)));
endmodule

// File: rtl/fsg_slot_match.sv
module fsg_slot_match #(
  parameter int unsigned SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              locked_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] tgt_slot_i,
  input  logic              en_i,
  output logic              fs_o
);
  logic hit;

  assign hit = locked_i && en_i && (tgt_slot_i == slot_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fs_o <= 1'b0;
    else if (boundary_i) fs_o <= hit;
  end

  // R10: the strobe only moves at a slot boundary
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(fs_o));

  // R5: a disabled entry never raises its strobe
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !en_i) |=> !fs_o);

  // R1: no strobe before the timing counter has seen a sync
  a_r1_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !locked_i) |=> !fs_o);
endmodule

// File: rtl/fsg_top.sv
module fsg_top
  import fsg_pkg::*;
#(
  parameter int unsigned SLOT_W     = FSG_SLOT_W,
  parameter int unsigned BIT_W      = FSG_BIT_W,
  parameter int unsigned CH_PER_DIR = FSG_CH_PER_DIR
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               mode_shared,
  input  logic                               tx_sync,
  input  logic                               rx_sync,
  input  logic [2*CH_PER_DIR*SLOT_W-1:0]     slot_tbl,
  input  logic [2*CH_PER_DIR-1:0]            slot_en,
  output logic [CH_PER_DIR-1:0]              tx_fs,
  output logic [CH_PER_DIR-1:0]              rx_fs,
  output logic                               tx_active_n
);
  localparam int unsigned NUM_OUT = 2 * CH_PER_DIR;
  localparam int unsigned NUM_DIR = 2;

  logic [NUM_DIR-1:0]    dir_sync;
  logic [SLOT_W-1:0]     dir_slot   [NUM_DIR];
  logic [NUM_DIR-1:0]    dir_bound;
  logic [NUM_DIR-1:0]    dir_locked;

  logic [SLOT_W-1:0]     rx_slot;
  logic                  rx_bound;
  logic                  rx_locked;
  logic [NUM_OUT-1:0]    fs_all;
  cnt_src_e              rx_src;

  // In shared mode the receive counter is left without syncs.
  assign dir_sync[0] = tx_sync;
  assign dir_sync[1] = rx_sync & ~mode_shared;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    fsg_frame_counter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_i       (dir_sync[d]),
      .slot_nxt_o   (dir_slot[d]),
      .boundary_o   (dir_bound[d]),
      .locked_nxt_o (dir_locked[d])
    );
  end

  assign rx_src = rx_source(mode_shared);

  always_comb begin
    if (rx_src == SRC_TX) begin
      rx_slot   = dir_slot[0];
      rx_bound  = dir_bound[0];
      rx_locked = dir_locked[0];
    end else begin
      rx_slot   = dir_slot[1];
      rx_bound  = dir_bound[1];
      rx_locked = dir_locked[1];
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (k < CH_PER_DIR) begin : g_tx
      fsg_slot_match #(.SLOT_W(SLOT_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (dir_bound[0]),
        .locked_i   (dir_locked[0]),
        .slot_i     (dir_slot[0]),
        .tgt_slot_i (slot_tbl[k*SLOT_W +: SLOT_W]),
        .en_i       (slot_en[k]),
        .fs_o       (fs_all[k])
      );
    end else begin : g_rx
      fsg_slot_match #(.SLOT_W(SLOT_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (rx_bound),
        .locked_i   (rx_locked),
        .slot_i     (rx_slot),
        .tgt_slot_i (slot_tbl[k*SLOT_W +: SLOT_W]),
        .en_i       (slot_en[k]),
        .fs_o       (fs_all[k])
      );
    end
  end

  assign tx_fs       = fs_all[CH_PER_DIR-1:0];
  assign rx_fs       = fs_all[NUM_OUT-1:CH_PER_DIR];
  assign tx_active_n = ~(|tx_fs);

  // R8: shared mode with a tx sync restarts receive strobes on the tx frame
  a_r8_shared_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_shared && tx_sync && slot_en[CH_PER_DIR] && slot_tbl[CH_PER_DIR*SLOT_W +: SLOT_W] == '0)
      |=> rx_fs[0]);

  // R2: tx sync with entry 0 on slot 0 gives tx strobe 0 in the next period
  a_r2_tx_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sync && slot_en[0] && slot_tbl[SLOT_W-1:0] == '0) |=> (tx_fs[0] && !tx_active_n));
endmodule

// File: tb/tb_fsg_top.sv
module tb_fsg_top;
  localparam int NO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_shared = 1'b0;
  logic        tx_sync = 1'b0;
  logic        rx_sync = 1'b0;
  logic [47:0] tbl = '0;
  logic [7:0]  en = '0;
  logic [3:0]  tx_fs, rx_fs;
  logic        tx_active_n;

  int n_run = 0;
  int n_fail = 0;

  // bench model state
  int   m_slot [2];
  int   m_bit  [2];
  bit   m_lock [2];
  bit   m_exp  [NO];

  // edge tracking for directed runs
  int rises [NO][4];
  int nrise [NO];
  int fall1 [NO];

  always #10 clk = ~clk;

  fsg_top dut (
    .clk(clk), .rst_n(rst_n), .mode_shared(mode_shared),
    .tx_sync(tx_sync), .rx_sync(rx_sync), .slot_tbl(tbl), .slot_en(en),
    .tx_fs(tx_fs), .rx_fs(rx_fs), .tx_active_n(tx_active_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit out_bit(input int o);
    return (o < 4) ? tx_fs[o] : rx_fs[o-4];
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_slot[d] = 63; m_bit[d] = 7; m_lock[d] = 0;
    end
    for (int o = 0; o < NO; o++) m_exp[o] = 0;
  endtask

  // Applied at each rising edge, using the inputs the design samples there.
  task automatic model_edge();
    bit bnd [2];
    for (int d = 0; d < 2; d++) begin
      bit s;
      s = (d == 0) ? tx_sync : (rx_sync && !mode_shared);
      if (s) begin
        m_slot[d] = 0; m_bit[d] = 0; m_lock[d] = 1;
      end else if (m_bit[d] == 7) begin
        m_bit[d] = 0; m_slot[d] = (m_slot[d] + 1) % 64;
      end else begin
        m_bit[d] = m_bit[d] + 1;
      end
      bnd[d] = (m_bit[d] == 0);
    end
    for (int o = 0; o < NO; o++) begin
      int src;
      src = (o < 4) ? 0 : (mode_shared ? 0 : 1);
      if (bnd[src])
        m_exp[o] = m_lock[src] && en[o] && (int'(tbl[o*6 +: 6]) == m_slot[src]);
    end
  endtask

  task automatic compare();
    logic [3:0] etx, erx;
    for (int o = 0; o < 4; o++) begin
      etx[o] = m_exp[o]; erx[o] = m_exp[o+4];
    end
    chk(tx_fs == etx, "R3 tx_fs", tx_fs, etx);
    chk(rx_fs == erx, mode_shared ? "R8 rx_fs" : "R7 rx_fs", rx_fs, erx);
    chk(tx_active_n == ~(|etx), "R9 tx_active_n", tx_active_n, ~(|etx));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_sync = 0; rx_sync = 0;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input int tx_at, input int rx_at,
                     input int chg_at, input int chg_k, input int chg_slot);
    bit prev [NO];
    for (int o = 0; o < NO; o++) begin
      nrise[o] = 0; fall1[o] = -1; prev[o] = out_bit(o);
    end
    for (int i = 0; i < n; i++) begin
      tx_sync = (i == tx_at);
      rx_sync = (i == rx_at);
      if (i == chg_at) tbl[chg_k*6 +: 6] = chg_slot[5:0];
      step();
      for (int o = 0; o < NO; o++) begin
        bit cur;
        cur = out_bit(o);
        if (cur && !prev[o]) begin
          if (nrise[o] < 4) rises[o][nrise[o]] = i;
          nrise[o]++;
        end
        if (!cur && prev[o] && fall1[o] < 0) fall1[o] = i;
        prev[o] = cur;
      end
    end
    tx_sync = 0; rx_sync = 0;
  endtask

  function automatic bit has_rise(input int o, input int t);
    for (int j = 0; j < 4; j++)
      if (j < nrise[o] && rises[o][j] == t) return 1;
    return 0;
  endfunction

  function automatic int first_rise(input int o);
    return (nrise[o] > 0) ? rises[o][0] : -1;
  endfunction

  task automatic set_entry(input int k, input int s, input bit e);
    tbl[k*6 +: 6] = s[5:0];
    en[k] = e;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));

    // R1: reset state and no strobes without a sync
    model_reset();
    #1;
    chk(tx_fs == 0 && rx_fs == 0 && tx_active_n == 1, "R1 during reset", {tx_fs, rx_fs}, 0);
    do_reset();
    for (int k = 0; k < NO; k++) set_entry(k, 0, 1);
    run(40, -1, -1, -1, 0, 0);
    for (int o = 0; o < NO; o++) chk(nrise[o] == 0, "R1 no strobe before sync", nrise[o], 0);

    // Split mode: R2 R3 R4 R5 R6 R7 R11
    do_reset();
    mode_shared = 0;
    en = '0;
    set_entry(0, 0, 1); set_entry(1, 5, 1); set_entry(2, 0, 0); set_entry(3, 63, 1);
    set_entry(6, 1, 1); set_entry(7, 5, 1);
    run(600, 0, 100, -1, 0, 0);
    chk(first_rise(0) == 0, "R2 slot0 rises right after sync", first_rise(0), 0);
    chk(fall1[0] == 8, "R3 slot0 width 8", fall1[0], 8);
    chk(first_rise(1) == 40, "R11 tx_fs[1] entry1 slot5", first_rise(1), 40);
    chk(fall1[1] == 48, "R3 slot5 width 8", fall1[1], 48);
    chk(first_rise(3) == 504, "R6 slot63 valid", first_rise(3), 504);
    chk(has_rise(0, 512), "R4 wrap repeats at 512", has_rise(0, 512), 1);
    chk(nrise[2] == 0, "R5 disabled stays low", nrise[2], 0);
    chk(first_rise(6) == 108, "R7 rx timed from rx_sync", first_rise(6), 108);
    chk(first_rise(7) == 140, "R11 rx_fs[3] entry7 slot5", first_rise(7), 140);

    // Shared mode: R8
    do_reset();
    mode_shared = 1;
    run(600, 0, 100, -1, 0, 0);
    chk(first_rise(6) == 8, "R8 rx timed from tx_sync", first_rise(6), 8);
    chk(!has_rise(6, 108), "R8 rx_sync ignored", has_rise(6, 108), 0);
    chk(has_rise(7, 40) && has_rise(1, 40), "R6 shared slot pulses together",
        has_rise(7, 40), 1);

    // R10: table change mid-strobe waits for the boundary
    do_reset();
    mode_shared = 0;
    run(100, 0, -1, 3, 0, 7);
    chk(fall1[0] == 8, "R10 strobe in progress completes", fall1[0], 8);
    chk(has_rise(0, 56), "R10 new slot from next frame position", has_rise(0, 56), 1);
    en[1] = 0;
    run(20, -1, -1, -1, 0, 0);

    // Constrained random against the bench model
    for (int k = 0; k < NO; k++) set_entry(k, $urandom_range(0, 7), $urandom_range(0, 3) != 0);
    for (int i = 0; i < 20000; i++) begin
      tx_sync = ($urandom_range(0, 700) == 0);
      rx_sync = ($urandom_range(0, 500) == 0);
      if ($urandom_range(0, 80) == 0)
        set_entry($urandom_range(0, 7), $urandom_range(0, 63), $urandom_range(0, 4) != 0);
      if ($urandom_range(0, 3000) == 0) mode_shared = ~mode_shared;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule